// File: doc/BRIEF.md
# Output Port Link Recovery Controller

This block is the transmit-side recovery engine of a serial packet link that numbers its packets with 5-bit acknowledge IDs. A symbol decoder gives it the incoming control symbols: packet-accepted, packet-retry, packet-not-accepted, and link-response with its returned ackID and a status bit. From these it asks the symbol encoder for restart-from-retry and link-request/input-status symbols. It also keeps the ackID of the next packet to transmit and the ackID of the oldest packet still waiting for an acknowledge.

Retry recovery and error recovery are separate machines. A retry costs one stopped cycle and rewinds transmission to the oldest unacknowledged packet. Error recovery sends a link-request and waits for the link-response. A programmable 24-bit timeout guards that wait, and the link-request is sent again a limited number of times. A fatal condition is held until the soft-reset input is raised. Packet storage, framing, CRC and symbol encoding belong to neighbouring blocks.

Top module: `olr_ctrl`

## Requirements
- R1: A packet-retry received while the block is neither error-stopped nor fatal raises `retry_stopped` and `send_rfr` for exactly one cycle, starting the cycle after the symbol. In that same cycle `tx_ackid` is rewound to `ack_pend_id`.
- R2: `retried` is set by an accepted packet-retry. It stays set until a packet-accepted or packet-not-accepted symbol is received.
- R3: A packet-not-accepted received while the block is neither error-stopped nor fatal raises `error_stopped` the next cycle and pulses `send_lreq` for one cycle. The block then waits for a link-response.
- R4: A link-response that arrives during the wait, has status OK and carries ackID `a` with (a − ack_pend_id) mod 32 ≤ (tx_ackid − ack_pend_id) mod 32 ends the error stop on the next cycle. It loads both `tx_ackid` and `ack_pend_id` with `a`.
- R5: A link-response during the wait with error status, or with an ackID outside that window, raises `fatal` on the next cycle. `fatal` stays high until `soft_rst` is sampled high.
- R6: If no link-response arrives, `send_lreq` pulses again TO×P+1 cycles after the previous pulse. TO is `timeout_val` and P = round(CLK_HZ×4.5/(2^24−1)), which is 54 at the default 200 MHz.
- R7: When the wait has timed out MAX_LREQ times (default 3) within one recovery, the block raises `fatal` TO×P+1 cycles after the last link-request, instead of sending another one.
- R8: `tx_pkt_sent` increments `tx_ackid` modulo 32. A packet-accepted whose ackID equals `ack_pend_id`, while `ack_pend_id` ≠ `tx_ackid`, increments `ack_pend_id`. Any other packet-accepted leaves `ack_pend_id` unchanged.
- R9: `port_stopped` is high exactly when `retry_stopped` or `error_stopped` is high. At most one of `retry_stopped`, `error_stopped` and `fatal` is high at a time.
- R10: After `rst_n` or a sampled `soft_rst`, both ackIDs are 0 and every flag and request output is low.
- R11: While error-stopped or fatal, packet-retry and packet-not-accepted symbols are ignored. While any stop or fatal state is active, `tx_pkt_sent` is ignored.
- R12: `sym_kind` is decoded when `sym_valid` is high: 1 = packet-accepted, 2 = packet-retry, 3 = packet-not-accepted, 4 = link-response. All other codes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous return to reset state, clears fatal |
| tx_pkt_sent | input | 1 | A packet was transmitted with the current `tx_ackid` |
| sym_valid | input | 1 | Decoded control symbol present |
| sym_kind | input | 3 | Symbol type code (R12) |
| sym_ackid | input | 5 | ackID carried by the symbol |
| sym_err_status | input | 1 | Link-response reports error status |
| timeout_val | input | 24 | Link timeout value |
| send_rfr | output | 1 | Request one restart-from-retry symbol |
| send_lreq | output | 1 | Request one link-request/input-status symbol |
| retry_stopped | output | 1 | Retry-stopped state |
| error_stopped | output | 1 | Error-stopped state |
| retried | output | 1 | Retry seen and not yet resolved |
| fatal | output | 1 | Unrecoverable link error |
| port_stopped | output | 1 | Either stopped state is active |
| tx_ackid | output | 5 | Next ackID to transmit |
| ack_pend_id | output | 5 | Next ackID expected to be acknowledged |

## Verification
Every symbol response is due one clock after the symbol is presented. This covers the stop flags, the request pulses, the ackID updates and `fatal`. The bench drives each input on a falling edge and reads the outputs on the next falling edge, so exactly one rising edge lies between stimulus and check. Timeout results come much later: a repeated link-request, or `fatal` after the last attempt, is due TO×P+1 cycles after the previous request pulse. The bench counts falling edges from that pulse and compares the measured gap with the count it derives from the clock frequency.

// File: rtl/olr_pkg.sv
package olr_pkg;

   typedef enum logic [2:0] {
      SYM_NONE  = 3'd0,
      SYM_ACC   = 3'd1,
      SYM_RTY   = 3'd2,
      SYM_NACK  = 3'd3,
      SYM_LRESP = 3'd4
   } sym_kind_e;

   typedef enum logic [1:0] {
      E_IDLE,
      E_SEND,
      E_WAIT,
      E_FATAL
   } err_st_e;

   // true when id lies in the window [pend, tx] modulo the ackID space
   function automatic logic ackid_in_window(input logic [7:0] id,
                                            input logic [7:0] pend,
                                            input logic [7:0] tx,
                                            input int         w);
      logic [7:0] mask;
      logic [7:0] d_id;
      logic [7:0] d_tx;
      mask = 8'((9'd1 << w) - 9'd1);
      d_id = (id - pend) & mask;
      d_tx = (tx - pend) & mask;
      return d_id <= d_tx;
   endfunction

endpackage

// File: rtl/olr_tick_gen.sv
module olr_tick_gen #(
   parameter int DIV = 54
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   output logic tick
);
   generate
      if (DIV <= 1) begin : g_direct
         assign tick = run;
      end else begin : g_count
         localparam int CW = $clog2(DIV);
         logic [CW-1:0] pcnt;
         assign tick = run && (pcnt == CW'(DIV - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      pcnt <= '0;
            else if (clr)    pcnt <= '0;
            else if (tick)   pcnt <= '0;
            else if (run)    pcnt <= pcnt + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/olr_timer.sv
module olr_timer #(
   parameter int TO_W = 24,
   parameter int DIV  = 54
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            run,
   input  logic [TO_W-1:0] limit,
   output logic            expired
);
   logic            tick;
   logic [TO_W-1:0] tcnt;

   olr_tick_gen #(.DIV(DIV)) tick_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .run   (run),
      .tick  (tick)
   );

   assign expired = tick && (tcnt == limit - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tcnt <= '0;
      else if (clr)    tcnt <= '0;
      else if (tick)   tcnt <= tcnt + 1'b1;
   end
endmodule

// File: rtl/olr_ackid_trk.sv
module olr_ackid_trk #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         rewind,
   input  logic         inc_tx,
   input  logic         inc_pend,
   output logic [W-1:0] tx_id,
   output logic [W-1:0] pend_id
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_id   <= '0;
         pend_id <= '0;
      end else if (clr) begin
         tx_id   <= '0;
         pend_id <= '0;
      end else if (load) begin
         tx_id   <= load_val;
         pend_id <= load_val;
      end else begin
         if (rewind)        tx_id <= pend_id;
         else if (inc_tx)   tx_id <= tx_id + 1'b1;
         if (inc_pend)      pend_id <= pend_id + 1'b1;
      end
   end
endmodule

// File: rtl/olr_ctrl.sv
module olr_ctrl #(
   parameter int ACKID_W  = 5,
   parameter int TO_W     = 24,
   parameter int CLK_HZ   = 200_000_000,
   parameter int MAX_LREQ = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               soft_rst,
   input  logic               tx_pkt_sent,
   input  logic               sym_valid,
   input  logic [2:0]         sym_kind,
   input  logic [ACKID_W-1:0] sym_ackid,
   input  logic               sym_err_status,
   input  logic [TO_W-1:0]    timeout_val,
   output logic               send_rfr,
   output logic               send_lreq,
   output logic               retry_stopped,
   output logic               error_stopped,
   output logic               retried,
   output logic               fatal,
   output logic               port_stopped,
   output logic [ACKID_W-1:0] tx_ackid,
   output logic [ACKID_W-1:0] ack_pend_id
);
   import olr_pkg::*;

   localparam logic [63:0] FULL_CNT = (64'd1 << TO_W) - 64'd1;
   localparam logic [63:0] DIV_RAW  = (64'(CLK_HZ) * 64'd9 + FULL_CNT) / (64'd2 * FULL_CNT);
   localparam int          TICK_DIV = (DIV_RAW == 64'd0) ? 1 : int'(DIV_RAW);
   localparam int          AW       = $clog2(MAX_LREQ + 1);

   generate
      if (ACKID_W < 2 || ACKID_W > 7) begin : g_bad_w
         $error("olr_ctrl: ACKID_W out of range");
      end
      if (MAX_LREQ < 1) begin : g_bad_max
         $error("olr_ctrl: MAX_LREQ must be at least 1");
      end
      if (TO_W < 4 || TO_W > 32) begin : g_bad_to
         $error("olr_ctrl: TO_W out of range");
      end
   endgenerate

   err_st_e         est_q, est_d;
   logic [AW-1:0]   tries_q, tries_d;
   logic            rty_q, retried_q;
   logic            expired;
   logic            is_acc, is_rty, is_nack, is_lresp;
   logic            in_err, is_fatal, rty_take, resp_ok;
   logic            ld_ids, inc_tx, inc_pend;

   assign is_acc   = sym_valid && (sym_kind == SYM_ACC);
   assign is_rty   = sym_valid && (sym_kind == SYM_RTY);
   assign is_nack  = sym_valid && (sym_kind == SYM_NACK);
   assign is_lresp = sym_valid && (sym_kind == SYM_LRESP);

   assign in_err   = (est_q == E_SEND) || (est_q == E_WAIT);
   assign is_fatal = (est_q == E_FATAL);
   assign rty_take = is_rty && !in_err && !is_fatal;

   assign resp_ok  = !sym_err_status &&
                     ackid_in_window(8'(sym_ackid), 8'(ack_pend_id), 8'(tx_ackid), ACKID_W);

   // error recovery machine
   always_comb begin
      est_d   = est_q;
      tries_d = tries_q;
      case (est_q)
         E_IDLE: if (is_nack) begin
            est_d   = E_SEND;
            tries_d = '0;
         end
         E_SEND: est_d = E_WAIT;
         E_WAIT: begin
            if (is_lresp) begin
               est_d = resp_ok ? E_IDLE : E_FATAL;
            end else if (expired) begin
               if (tries_q == AW'(MAX_LREQ - 1)) begin
                  est_d = E_FATAL;
               end else begin
                  est_d   = E_SEND;
                  tries_d = tries_q + 1'b1;
               end
            end
         end
         default: est_d = E_FATAL;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         est_q     <= E_IDLE;
         tries_q   <= '0;
         rty_q     <= 1'b0;
         retried_q <= 1'b0;
      end else if (soft_rst) begin
         est_q     <= E_IDLE;
         tries_q   <= '0;
         rty_q     <= 1'b0;
         retried_q <= 1'b0;
      end else begin
         est_q   <= est_d;
         tries_q <= tries_d;
         rty_q   <= rty_take;
         if (rty_take)                retried_q <= 1'b1;
         else if (is_acc || is_nack)  retried_q <= 1'b0;
      end
   end

   olr_timer #(.TO_W(TO_W), .DIV(TICK_DIV)) timer_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (soft_rst || (est_q == E_SEND)),
      .run     (est_q == E_WAIT),
      .limit   (timeout_val),
      .expired (expired)
   );

   assign ld_ids   = (est_q == E_WAIT) && is_lresp && resp_ok;
   assign inc_tx   = tx_pkt_sent && !rty_q && !in_err && !is_fatal;
   assign inc_pend = is_acc && !is_fatal && (sym_ackid == ack_pend_id) &&
                     (ack_pend_id != tx_ackid);

   olr_ackid_trk #(.W(ACKID_W)) ids_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (soft_rst),
      .load     (ld_ids),
      .load_val (sym_ackid),
      .rewind   (rty_take),
      .inc_tx   (inc_tx),
      .inc_pend (inc_pend),
      .tx_id    (tx_ackid),
      .pend_id  (ack_pend_id)
   );

   assign retry_stopped = rty_q;
   assign send_rfr      = rty_q;
   assign error_stopped = in_err;
   assign send_lreq     = (est_q == E_SEND);
   assign fatal         = is_fatal;
   assign retried       = retried_q;
   assign port_stopped  = rty_q || in_err;
endmodule

// File: rtl/olr_ctrl_chk.sv
module olr_ctrl_chk #(
   parameter int ACKID_W = 5,
   parameter int TO_W    = 24
) (
   input logic               clk,
   input logic               rst_n,
   input logic               soft_rst,
   input logic               tx_pkt_sent,
   input logic               sym_valid,
   input logic [2:0]         sym_kind,
   input logic [ACKID_W-1:0] sym_ackid,
   input logic               sym_err_status,
   input logic [TO_W-1:0]    timeout_val,
   input logic               send_rfr,
   input logic               send_lreq,
   input logic               retry_stopped,
   input logic               error_stopped,
   input logic               retried,
   input logic               fatal,
   input logic               port_stopped,
   input logic [ACKID_W-1:0] tx_ackid,
   input logic [ACKID_W-1:0] ack_pend_id
);
   p_rfr_issue_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_valid && sym_kind == 3'd2 && !error_stopped && !fatal && !soft_rst)
      |=> (retry_stopped && send_rfr));

   p_rfr_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (retry_stopped && !(sym_valid && sym_kind == 3'd2)) |=> !retry_stopped);

   p_retried_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (retried && !soft_rst && !(sym_valid && (sym_kind == 3'd1 || sym_kind == 3'd3)))
      |=> retried);

   p_lreq_on_nack_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_valid && sym_kind == 3'd3 && !error_stopped && !fatal && !soft_rst)
      |=> (error_stopped && send_lreq));

   p_lresp_err_fatal_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (error_stopped && !send_lreq && sym_valid && sym_kind == 3'd4 &&
       sym_err_status && !soft_rst) |=> fatal);

   p_fatal_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fatal && !soft_rst) |=> fatal);

   p_state_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({retry_stopped, error_stopped, fatal}));

   p_soft_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (tx_ackid == '0 && ack_pend_id == '0 && !fatal && !retried));

   p_tx_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (error_stopped && !soft_rst && !(sym_valid && sym_kind == 3'd4))
      |=> $stable(tx_ackid));
endmodule

bind olr_ctrl olr_ctrl_chk #(.ACKID_W(ACKID_W), .TO_W(TO_W)) chk_i (.*);

// File: tb/olr_ctrl_tb.sv
`timescale 1ns/1ps
module olr_ctrl_tb_top;
   localparam int CLK_HZ = 200_000_000;
   localparam int TO     = 16;
   localparam int MAXR   = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        soft_rst = 1'b0;
   logic        tx_pkt_sent = 1'b0;
   logic        sym_valid = 1'b0;
   logic [2:0]  sym_kind = 3'd0;
   logic [4:0]  sym_ackid = 5'd0;
   logic        sym_err_status = 1'b0;
   logic [23:0] timeout_val = 24'(TO);
   logic        send_rfr, send_lreq, retry_stopped, error_stopped;
   logic        retried, fatal, port_stopped;
   logic [4:0]  tx_ackid, ack_pend_id;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   olr_ctrl #(.CLK_HZ(CLK_HZ), .MAX_LREQ(MAXR)) dut_i (.*);

   // prescale per R6, derived from the clock rate
   function automatic int presc();
      real r;
      r = real'(CLK_HZ) * 4.5 / 16777215.0;
      return int'(r + 0.5) > 0 ? int'(r + 0.5) : 1;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   // drive one symbol for one cycle; returns on the falling edge where results show
   task automatic sym(input logic [2:0] k, input logic [4:0] id, input logic es);
      @(negedge clk);
      sym_valid = 1'b1; sym_kind = k; sym_ackid = id; sym_err_status = es;
      @(negedge clk);
      sym_valid = 1'b0; sym_kind = 3'd0; sym_ackid = 5'd0; sym_err_status = 1'b0;
   endtask

   task automatic send_pkts(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tx_pkt_sent = 1'b1;
      end
      @(negedge clk);
      tx_pkt_sent = 1'b0;
   endtask

   task automatic do_soft_rst();
      @(negedge clk);
      soft_rst = 1'b1;
      @(negedge clk);
      soft_rst = 1'b0;
   endtask

   task automatic t_reset();
      chk("R10 tx_ackid", tx_ackid, 0);
      chk("R10 ack_pend_id", ack_pend_id, 0);
      chk("R10 flags", {send_rfr, send_lreq, retry_stopped, error_stopped,
                        retried, fatal, port_stopped}, 0);
   endtask

   task automatic t_count();
      send_pkts(3);
      chk("R8 tx count", tx_ackid, 3);
      sym(3'd1, 5'd0, 1'b0);
      chk("R8 accept advances", ack_pend_id, 1);
      sym(3'd1, 5'd5, 1'b0);
      chk("R8 wrong ackid ignored", ack_pend_id, 1);
      sym(3'd6, 5'd1, 1'b0);
      chk("R12 unknown code ignored", ack_pend_id, 1);
   endtask

   task automatic t_retry();
      sym(3'd2, 5'd1, 1'b0);
      chk("R1 retry_stopped", retry_stopped, 1);
      chk("R1 send_rfr", send_rfr, 1);
      chk("R9 port_stopped in retry", port_stopped, 1);
      chk("R2 retried set", retried, 1);
      chk("R1 rewind", tx_ackid, 1);
      @(negedge clk);
      chk("R1 single cycle", {retry_stopped, send_rfr}, 0);
      chk("R9 port_stopped clears", port_stopped, 0);
      chk("R2 retried held", retried, 1);
      send_pkts(1);
      chk("R2 retried held on send", retried, 1);
      chk("R8 resend", tx_ackid, 2);
      sym(3'd1, 5'd1, 1'b0);
      chk("R2 retried cleared", retried, 0);
      chk("R8 advance after retry", ack_pend_id, 2);
   endtask

   task automatic t_recover();
      send_pkts(3);
      chk("R8 tx before nack", tx_ackid, 5);
      sym(3'd3, 5'd2, 1'b0);
      chk("R3 error_stopped", error_stopped, 1);
      chk("R3 send_lreq", send_lreq, 1);
      chk("R9 port_stopped err", port_stopped, 1);
      @(negedge clk);
      chk("R3 lreq one cycle", send_lreq, 0);
      chk("R3 still waiting", error_stopped, 1);
      send_pkts(2);
      chk("R11 send ignored", tx_ackid, 5);
      sym(3'd2, 5'd2, 1'b0);
      chk("R11 retry ignored", retry_stopped, 0);
      chk("R11 retry no rewind", tx_ackid, 5);
      sym(3'd4, 5'd4, 1'b0);
      chk("R4 error stop ends", error_stopped, 0);
      chk("R4 tx reload", tx_ackid, 4);
      chk("R4 pend reload", ack_pend_id, 4);
      chk("R4 not fatal", fatal, 0);
   endtask

   task automatic t_timeout();
      int cyc = 0;
      int pulses = 0;
      int last = 0;
      int gap1 = -1;
      int fat_at = -1;
      int exp_gap;
      exp_gap = TO * presc() + 1;
      sym(3'd3, 5'd4, 1'b0);
      if (send_lreq) begin pulses = 1; last = 0; end
      while (cyc < 8 * exp_gap && fat_at < 0) begin
         @(negedge clk);
         cyc++;
         if (send_lreq) begin
            if (pulses == 1) gap1 = cyc - last;
            pulses++;
            last = cyc;
         end
         if (fatal) fat_at = cyc;
      end
      chk("R6 reissue period", gap1, exp_gap);
      chk("R7 attempts", pulses, MAXR);
      chk("R7 fatal timing", fat_at - last, exp_gap);
      sym(3'd3, 5'd0, 1'b0);
      chk("R11 nack ignored in fatal", error_stopped, 0);
      chk("R5 fatal held", fatal, 1);
      do_soft_rst();
      chk("R5 soft reset clears fatal", fatal, 0);
      chk("R10 soft reset ids", {tx_ackid, ack_pend_id}, 0);
   endtask

   task automatic t_bad_ackid();
      send_pkts(2);
      sym(3'd3, 5'd0, 1'b0);
      @(negedge clk);
      sym(3'd4, 5'd7, 1'b0);
      chk("R5 out-of-window fatal", fatal, 1);
      chk("R9 fatal not stopped", port_stopped, 0);
      do_soft_rst();
      send_pkts(2);
      sym(3'd3, 5'd0, 1'b0);
      @(negedge clk);
      sym(3'd4, 5'd2, 1'b0);
      chk("R4 edge ackid accepted", {fatal, error_stopped}, 0);
      chk("R4 edge reload", ack_pend_id, 2);
      sym(3'd3, 5'd2, 1'b0);
      @(negedge clk);
      sym(3'd4, 5'd2, 1'b1);
      chk("R5 error status fatal", fatal, 1);
      do_soft_rst();
   endtask

   task automatic t_wrap();
      send_pkts(33);
      chk("R8 wrap", tx_ackid, 1);
      do_soft_rst();
      chk("R10 after wrap reset", tx_ackid, 0);
   endtask

   initial begin
      #(5.0 * 150000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_count();
      t_retry();
      t_recover();
      t_timeout();
      t_bad_ackid();
      t_wrap();
      summary();
   end
endmodule